// File: doc/BRIEF.md
# Dual-Reload PWM Timer with Duty Saturation

The block is a down-counting PWM timer that alternates between two reload values, an "A" length and a "B" length. It drives an output flip-flop that inverts at each boundary between phases. Counting advances only in cycles where the count-clock enable is high. A reload value of all ones does not count as a length. It marks its phase as saturated: that phase lasts a single count and no boundary next to it inverts the output. With this, software can hold the output at a constant level (0% or 100% duty) without stopping the timer. The period still elapses and every boundary still produces its events.

Every boundary produces two pulses. A start pulse for neighbouring timers comes out in the same cycle as the boundary. An interrupt/DMA request pulse follows at the next count tick, and the output inversion happens at that same tick. The delay exists because the saturation decision is taken when the counter reloads. A single-shot mode runs one A phase and one B phase and then halts with the output low. A stop request wins over a start request that arrives in the same cycle. A counter write of all ones while running is refused.

Top module: `dr_pwm_timer`

## Requirements
- R1: After a start the counter loads the A reload value. A phase with reload value v (not all ones) lasts v+1 count ticks, and phases alternate A, B, A, B.
- R2: `pwm_out` is 0 after reset. When neither neighbouring phase is saturated, it inverts once per boundary, so in steady state it is high for the length of the B phase in each period.
- R3: A reload value of all ones makes its phase last exactly one count tick. No inversion of `pwm_out` happens at the boundary entering that phase or at the boundary leaving it.
- R4: `cfg_err` is 1 exactly while both reload registers hold all ones. In that state the phases still run, one tick each, and `pwm_out` does not change.
- R5: A write to `cnt_wdata` with `cnt_we` loads the counter, and the next boundary follows value+1 ticks later. A write of all ones while the timer runs is ignored and the phase ends on its original schedule.
- R6: `trig_pulse` is high for one cycle directly after the clock edge at which a phase ends, for every boundary including saturated ones.
- R7: `irq_pulse` is high for one cycle, and any inversion of `pwm_out` takes effect, at the first count tick after the boundary. Without a tick, neither changes.
- R8: A reload register write is used only at a later counter load. A write landing in the same cycle as a boundary is not used by the load in that cycle.
- R9: With `single_shot` high, the timer runs one A phase and one B phase, produces two boundaries, stops, and leaves `pwm_out` at 0 after the last request.
- R10: `stop` halts counting so that no further boundaries occur. When `start` and `stop` are high in the same cycle, the timer stays idle.
- R11: The counter moves only in cycles where `cnt_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count tick enable |
| start | input | 1 | Start request (ignored while running) |
| stop | input | 1 | Stop request, wins over start |
| single_shot | input | 1 | 1 = run one A and one B phase, then halt |
| rld_a_we | input | 1 | Write strobe for the A reload register |
| rld_a_wdata | input | W | A reload value (all ones = saturate) |
| rld_b_we | input | 1 | Write strobe for the B reload register |
| rld_b_wdata | input | W | B reload value (all ones = saturate) |
| cnt_we | input | 1 | Direct counter write strobe |
| cnt_wdata | input | W | Direct counter write value |
| pwm_out | output | 1 | PWM flip-flop output |
| irq_pulse | output | 1 | Interrupt/DMA request, one cycle per boundary |
| trig_pulse | output | 1 | Start pulse for other timers, one cycle per boundary |
| cfg_err | output | 1 | Both reload registers hold all ones |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a reload register write and the boundary that reloads from that register. The bench times the A-register write so that it is sampled on the edge where the B phase ends. It then checks that the next A phase keeps the old length and that the phase after that takes the new length. The second pair is start and stop: the bench raises both for one cycle and checks that no boundary pulse follows. With a one-tick phase, servicing the previous request and starting the next boundary also fall in the same tick. The all-zero reload vector covers this case by checking the request count and the duty over a window.

// File: rtl/dr_pwm_pkg.sv
package dr_pwm_pkg;
   typedef enum logic {
      PH_A = 1'b0,
      PH_B = 1'b1
   } phase_t;
endpackage

// File: rtl/dr_pwm_reload_bank.sv
module dr_pwm_reload_bank #(
   parameter int W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          we,
   input  logic [1:0][W-1:0]   wdata,
   output logic [1:0][W-1:0]   value,
   output logic [1:0]          sat,
   output logic                both_sat
);
   localparam logic [W-1:0] ONES = {W{1'b1}};

   for (genvar i = 0; i < 2; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            value[i] <= '0;
         else if (we[i])
            value[i] <= wdata[i];
      end
      assign sat[i] = (value[i] == ONES);
   end

   assign both_sat = &sat;
endmodule

// File: rtl/dr_pwm_core.sv
module dr_pwm_core
   import dr_pwm_pkg::*;
#(
   parameter int W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                start,
   input  logic                stop,
   input  logic                single_shot,
   input  logic                cnt_we,
   input  logic [W-1:0]        cnt_wdata,
   input  logic [1:0][W-1:0]   rld_val,
   input  logic [1:0]          rld_sat,
   output logic                run_o,
   output logic                bnd_o,
   output logic                tog_ok_o,
   output logic                shot_end_o,
   output logic [W-1:0]        cnt_o
);
   localparam logic [W-1:0] ONES = {W{1'b1}};

   phase_t       phase;
   logic [W-1:0] cnt;
   logic         run;
   logic         cur_sat;
   logic         start_go;
   logic         wr_ok;
   logic         nxt_idx;
   logic         nxt_sat;
   logic [W-1:0] nxt_len;
   logic [W-1:0] a_len;

   assign start_go = start && !stop && !run;
   assign wr_ok    = cnt_we && !start_go && !(run && cnt_wdata == ONES);
   assign nxt_idx  = (phase == PH_A);
   assign nxt_sat  = rld_sat[nxt_idx];
   assign nxt_len  = nxt_sat ? '0 : rld_val[nxt_idx];
   assign a_len    = rld_sat[0] ? '0 : rld_val[0];
   assign bnd_o    = run && !stop && tick && !wr_ok && (cnt == '0);
   assign tog_ok_o = !cur_sat && !nxt_sat;
   assign shot_end_o = single_shot && (phase == PH_B);
   assign run_o    = run;
   assign cnt_o    = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run     <= 1'b0;
         phase   <= PH_A;
         cnt     <= '0;
         cur_sat <= 1'b0;
      end else if (start_go) begin
         run     <= 1'b1;
         phase   <= PH_A;
         cnt     <= a_len;
         cur_sat <= rld_sat[0];
      end else begin
         if (stop)
            run <= 1'b0;
         if (wr_ok) begin
            cnt <= cnt_wdata;
         end else if (bnd_o) begin
            phase   <= (phase == PH_A) ? PH_B : PH_A;
            cnt     <= nxt_len;
            cur_sat <= nxt_sat;
            if (shot_end_o)
               run <= 1'b0;
         end else if (run && tick && !stop) begin
            cnt <= cnt - 1'b1;
         end
      end
   end
endmodule

// File: rtl/dr_pwm_out.sv
module dr_pwm_out (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic bnd,
   input  logic tog_ok,
   input  logic shot_end,
   output logic pwm_q,
   output logic irq_q,
   output logic trig_q
);
   logic pend;
   logic pend_tog;
   logic pend_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend     <= 1'b0;
         pend_tog <= 1'b0;
         pend_end <= 1'b0;
         pwm_q    <= 1'b0;
         irq_q    <= 1'b0;
         trig_q   <= 1'b0;
      end else begin
         trig_q <= bnd;
         irq_q  <= 1'b0;
         if (pend && tick) begin
            irq_q <= 1'b1;
            pwm_q <= pend_end ? 1'b0 : (pwm_q ^ pend_tog);
            pend  <= 1'b0;
         end
         if (bnd) begin
            pend     <= 1'b1;
            pend_tog <= tog_ok;
            pend_end <= shot_end;
         end
      end
   end
endmodule

// File: rtl/dr_pwm_timer.sv
module dr_pwm_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cnt_en,
   input  logic         start,
   input  logic         stop,
   input  logic         single_shot,
   input  logic         rld_a_we,
   input  logic [W-1:0] rld_a_wdata,
   input  logic         rld_b_we,
   input  logic [W-1:0] rld_b_wdata,
   input  logic         cnt_we,
   input  logic [W-1:0] cnt_wdata,
   output logic         pwm_out,
   output logic         irq_pulse,
   output logic         trig_pulse,
   output logic         cfg_err
);
   if (W < 2 || W > 32) begin : g_bad_width
      $error("dr_pwm_timer: W must lie in 2..32");
   end

   logic [1:0][W-1:0] rld_val;
   logic [1:0]        rld_sat;
   logic              run_w;
   logic              bnd_w;
   logic              tog_w;
   logic              end_w;
   logic [W-1:0]      cnt_w;

   dr_pwm_reload_bank #(.W(W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       ({rld_b_we, rld_a_we}),
      .wdata    ({rld_b_wdata, rld_a_wdata}),
      .value    (rld_val),
      .sat      (rld_sat),
      .both_sat (cfg_err)
   );

   dr_pwm_core #(.W(W)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (cnt_en),
      .start       (start),
      .stop        (stop),
      .single_shot (single_shot),
      .cnt_we      (cnt_we),
      .cnt_wdata   (cnt_wdata),
      .rld_val     (rld_val),
      .rld_sat     (rld_sat),
      .run_o       (run_w),
      .bnd_o       (bnd_w),
      .tog_ok_o    (tog_w),
      .shot_end_o  (end_w),
      .cnt_o       (cnt_w)
   );

   dr_pwm_out u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (cnt_en),
      .bnd      (bnd_w),
      .tog_ok   (tog_w),
      .shot_end (end_w),
      .pwm_q    (pwm_out),
      .irq_q    (irq_pulse),
      .trig_q   (trig_pulse)
   );
endmodule

// File: rtl/dr_pwm_chk.sv
module dr_pwm_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         stop,
   input logic         cnt_we,
   input logic [W-1:0] cnt_wdata,
   input logic         pwm_out,
   input logic         irq_pulse,
   input logic         trig_pulse,
   input logic         run,
   input logic [W-1:0] cnt
);
   localparam logic [W-1:0] ONES = {W{1'b1}};

   assert_pwm_moves_with_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pwm_out) |-> irq_pulse);

   assert_ones_write_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt_we && cnt_wdata == ONES) |=> (cnt != ONES));

   assert_halt_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run) |-> (trig_pulse || $past(stop)));

   assert_trig_needs_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |-> $past(run));
endmodule

bind dr_pwm_timer dr_pwm_chk #(.W(W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stop       (stop),
   .cnt_we     (cnt_we),
   .cnt_wdata  (cnt_wdata),
   .pwm_out    (pwm_out),
   .irq_pulse  (irq_pulse),
   .trig_pulse (trig_pulse),
   .run        (run_w),
   .cnt        (cnt_w)
);

// File: tb/tb_dr_pwm_timer.sv
`timescale 1ns/1ps
module tb_dr_pwm_timer;
   localparam int W = 16;
   localparam int NV = 6;
   localparam int K = 3;
   localparam logic [W-1:0] VA [NV] = '{16'h0004, 16'h0007, 16'h0008, 16'h0008, 16'hFFFF, 16'h0000};
   localparam logic [W-1:0] VB [NV] = '{16'h0004, 16'h0001, 16'h0000, 16'hFFFF, 16'h0003, 16'h0000};
   localparam int VFIRST [NV] = '{5, 8, 9, 9, 1, 1};
   localparam int VHIGH  [NV] = '{5, 2, 1, 0, 0, 1};
   localparam int VPER   [NV] = '{10, 10, 10, 10, 5, 2};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cnt_en = 1'b0, start = 1'b0, stop = 1'b0, single_shot = 1'b0;
   logic rld_a_we = 1'b0, rld_b_we = 1'b0, cnt_we = 1'b0;
   logic [W-1:0] rld_a_wdata = '0, rld_b_wdata = '0, cnt_wdata = '0;
   logic pwm_out, irq_pulse, trig_pulse, cfg_err;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dr_pwm_timer #(.W(W)) dut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .start(start), .stop(stop),
      .single_shot(single_shot), .rld_a_we(rld_a_we), .rld_a_wdata(rld_a_wdata),
      .rld_b_we(rld_b_we), .rld_b_wdata(rld_b_wdata), .cnt_we(cnt_we),
      .cnt_wdata(cnt_wdata), .pwm_out(pwm_out), .irq_pulse(irq_pulse),
      .trig_pulse(trig_pulse), .cfg_err(cfg_err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; cnt_en = 1'b1; start = 1'b0; stop = 1'b0; single_shot = 1'b0;
      rld_a_we = 1'b0; rld_b_we = 1'b0; cnt_we = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic load_reloads(input logic [W-1:0] a, input logic [W-1:0] b);
      rld_a_we = 1'b1; rld_a_wdata = a;
      rld_b_we = 1'b1; rld_b_wdata = b;
      @(negedge clk);
      rld_a_we = 1'b0; rld_b_we = 1'b0;
   endtask

   task automatic kick();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_trig(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!trig_pulse && n < 1000);
   endtask

   task automatic window(input int len, output int t, output int h, output int q);
      t = 0; h = 0; q = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         t += int'(trig_pulse);
         h += int'(pwm_out);
         q += int'(irq_pulse);
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      int n, t, h, q;

      // reset state (R2, R4)
      do_reset();
      check(pwm_out == 1'b0, "R2 reset pwm", int'(pwm_out), 0);
      check(irq_pulse == 1'b0 && trig_pulse == 1'b0, "R6 reset pulses",
            int'(irq_pulse) + int'(trig_pulse), 0);
      check(cfg_err == 1'b0, "R4 reset cfg_err", int'(cfg_err), 0);

      // vector table: R1 first phase, R2/R3 duty, R6/R7 pulse counts
      for (int v = 0; v < NV; v++) begin
         do_reset();
         load_reloads(VA[v], VB[v]);
         kick();
         wait_trig(n);
         check(n == VFIRST[v], "R1 first phase length", n, VFIRST[v]);
         window(K * VPER[v], t, h, q);
         check(h == K * VHIGH[v], "R3 high samples per window", h, K * VHIGH[v]);
         check(t == 2 * K, "R6 boundary pulses per window", t, 2 * K);
         check(q == 2 * K, "R7 requests per window", q, 2 * K);
      end

      // R7 / R11: request and inversion wait for the next tick
      do_reset();
      load_reloads(16'd2, 16'd2);
      kick();
      wait_trig(n);
      check(n == 3, "R1 phase length 3", n, 3);
      cnt_en = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(irq_pulse == 1'b0 && pwm_out == 1'b0, "R11 no tick no change",
               int'(irq_pulse) + int'(pwm_out), 0);
      end
      cnt_en = 1'b1;
      @(negedge clk);
      check(irq_pulse == 1'b1, "R7 request on first tick", int'(irq_pulse), 1);
      check(pwm_out == 1'b1, "R7 inversion on first tick", int'(pwm_out), 1);

      // R4: both saturated
      do_reset();
      load_reloads(16'hFFFF, 16'hFFFF);
      check(cfg_err == 1'b1, "R4 cfg_err set", int'(cfg_err), 1);
      kick();
      window(10, t, h, q);
      check(t == 10, "R4 one-tick phases keep running", t, 10);
      check(h == 0, "R4 output never inverts", h, 0);

      // R5: counter write of all ones refused, legal write accepted
      do_reset();
      load_reloads(16'd9, 16'd9);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cnt_we = 1'b1; cnt_wdata = 16'hFFFF;
      @(negedge clk);
      cnt_we = 1'b0;
      wait_trig(n);
      check(n == 9, "R5 ones write ignored", n, 9);
      cnt_we = 1'b1; cnt_wdata = 16'd2;
      @(negedge clk);
      cnt_we = 1'b0;
      wait_trig(n);
      check(n == 3, "R5 legal write reloads counter", n, 3);

      // R8: reload write in the boundary cycle
      do_reset();
      load_reloads(16'd3, 16'd3);
      kick();
      wait_trig(n);
      repeat (3) @(negedge clk);
      rld_a_we = 1'b1; rld_a_wdata = 16'd0;
      @(negedge clk);
      rld_a_we = 1'b0;
      check(trig_pulse == 1'b1, "R8 write aligned with boundary", int'(trig_pulse), 1);
      wait_trig(n);
      check(n == 4, "R8 A phase keeps old length", n, 4);
      wait_trig(n);
      check(n == 4, "R8 B phase unchanged", n, 4);
      wait_trig(n);
      check(n == 1, "R8 new A length used", n, 1);

      // R10: start and stop together, then stop while running
      do_reset();
      load_reloads(16'd1, 16'd1);
      start = 1'b1; stop = 1'b1;
      @(negedge clk);
      start = 1'b0; stop = 1'b0;
      window(10, t, h, q);
      check(t == 0, "R10 stop wins over start", t, 0);
      kick();
      wait_trig(n);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      window(10, t, h, q);
      check(t == 0, "R10 stop halts boundaries", t, 0);

      // R9: single shot
      do_reset();
      load_reloads(16'd2, 16'd4);
      single_shot = 1'b1;
      kick();
      window(20, t, h, q);
      check(t == 2, "R9 two boundaries", t, 2);
      check(h == 5, "R9 high for B phase", h, 5);
      check(q == 2, "R9 two requests", q, 2);
      check(pwm_out == 1'b0, "R9 idle level after shot", int'(pwm_out), 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule